// File: doc/BRIEF.md
# Extended Capability Chain Engine

This block walks, and extends, the singly linked chain of extended capability headers kept in a 4 KB configuration RAM. The chain always begins at byte offset 0x100. Each 32-bit header holds a 16-bit capability identifier in bits [15:0], a 4-bit version in bits [19:16] and a 12-bit byte offset of the following header in bits [31:20]. A following offset of zero marks the last header.

A caller issues one command per `cmd_valid` pulse while the engine is idle. A lookup command searches for an identifier and returns the byte offset of the first matching header (or 0) together with the offset of the header visited before it. An insert command places a new header at a given offset. When that offset is not the head, the engine first walks to the last header and rewrites only its following-offset field so that it points to the new header. Internally, the walk for an insert is a lookup that can never match, so the same walker finds the tail. The RAM is addressed in 32-bit words (byte offset shifted right by two) and returns read data one cycle after the request.

The control is a single state machine with states IDLE, READ, EVAL, PATCH, WRITE, DONE and FAIL. Its transitions are:
- IDLE to READ on a lookup, or on an insert that is not at the head.
- IDLE to WRITE on an insert at the head.
- IDLE to FAIL on an insert with bad parameters.
- READ to EVAL.
- EVAL back to READ to follow a valid link.
- EVAL to DONE on a match, on the end of a lookup, or on an empty chain during a lookup.
- EVAL to PATCH at the tail during an insert.
- EVAL to FAIL on a bad link, on exceeding the step limit, or on an insert into an empty chain.
- PATCH to WRITE, WRITE to DONE, and DONE or FAIL back to IDLE.

Top module: `xcap_walker`

## Requirements
- R1: After reset the engine is idle: `done`, `err`, `ram_en` and `ram_we` are all low.
- R2: When the word at offset 0x100 is zero, a lookup finishes with `res_off`=0 and `res_prev`=0 after one RAM read.
- R3: A lookup stops at the first header whose bits [15:0] equal the requested identifier. It returns that header's offset in `res_off` and the offset of the header visited before it in `res_prev` (0 when the match is the head). A lookup never writes the RAM.
- R4: A following-offset field (bits [31:20]) of zero ends the chain. A lookup that reaches it without a match returns `res_off`=0 and `res_prev` equal to the offset of the last header.
- R5: A requested identifier with any bit at or above bit 16 set never matches, even when its low 16 bits equal a stored identifier. The result is `res_off`=0 and `res_prev` equal to the last header.
- R6: An insert at offset 0x100 performs no reads. It writes the word {next=0, version, identifier} at word address 0x40 and returns `res_off`=0x100 and `res_prev`=0.
- R7: An insert at any other offset first walks to the tail. It then rewrites the tail word with bits [31:20] set to the new offset and bits [19:0] unchanged, then writes {next=0, version, identifier} at the new offset. It returns the new offset and the tail offset.
- R8: An insert is rejected with `err` and no RAM access in any of these cases: its offset is below 0x100, its offset is not a multiple of 4, its size is below 8 bytes, or offset plus size exceeds 0x1000.
- R9: A walk reports `err` when a nonzero following offset is not a multiple of 4, is below 0x100, or is above 0xFF8.
- R10: A walk that would have to visit more than MAX_STEPS headers reports `err`. A chain of exactly MAX_STEPS headers completes normally.
- R11: Each visited header costs one READ and one EVAL cycle. After the accepting edge, a lookup that visits n headers raises `done` after 2n edges, and an insert past n headers raises it after 2n+2. `done` is a one-cycle pulse.
- R12: An insert at an offset other than 0x100 into an empty chain reports `err` after one RAM read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command (honoured in IDLE) |
| cmd_append | input | 1 | 1 = insert, 0 = lookup |
| cmd_id | input | REQ_ID_W | Requested identifier; bits above 15 make a lookup unmatchable |
| cmd_ver | input | 4 | Version for an inserted header |
| cmd_off | input | 12 | Byte offset for an inserted header |
| cmd_size | input | SIZE_W | Byte size of the inserted capability |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error, valid with `done` |
| res_off | output | 12 | Matched or inserted offset, else 0 |
| res_prev | output | 12 | Offset of the preceding or tail header |
| ram_en | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 10 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after a read |

## Verification
The bench builds the engine with MAX_STEPS=6 and default widths (17-bit request identifier, 13-bit size). With that limit, a six-header chain and a three-header cycle that laps twice are both reachable in a few dozen cycles, which puts the exact boundary between completion and loop error under test. The 17-bit request field makes an identifier whose low half matches a stored header, but which can never match, easy to drive.

// File: rtl/xcap_pkg.sv
package xcap_pkg;

    localparam int OFF_W   = 12;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = OFF_W - 2;
    localparam int ID_W    = 16;
    localparam int VER_W   = 4;
    localparam int CFG_BYTES = 1 << OFF_W;

    typedef struct packed {
        logic [OFF_W-1:0] nxt;
        logic [VER_W-1:0] ver;
        logic [ID_W-1:0]  id;
    } cap_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_PATCH,
        ST_WRITE,
        ST_DONE,
        ST_FAIL
    } walk_st_e;

endpackage

// File: rtl/xcap_hdr_unpack.sv
module xcap_hdr_unpack
    import xcap_pkg::*;
#(
    parameter logic [OFF_W-1:0] HEAD = 12'h100
) (
    input  logic [WORD_W-1:0] word,
    output cap_hdr_t          hdr,
    output logic              nxt_ok
);
    localparam int LAST_NEXT = CFG_BYTES - 8;

    always_comb begin
        hdr    = cap_hdr_t'(word);
        nxt_ok = (hdr.nxt[1:0] == 2'b00) &&
                 (hdr.nxt >= HEAD) &&
                 (hdr.nxt <= LAST_NEXT[OFF_W-1:0]);
    end
endmodule

// File: rtl/xcap_append_check.sv
module xcap_append_check
    import xcap_pkg::*;
#(
    parameter logic [OFF_W-1:0] HEAD   = 12'h100,
    parameter int               SIZE_W = 13
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [SIZE_W-1:0] size,
    output logic              ok
);
    localparam int EW = ((OFF_W > SIZE_W) ? OFF_W : SIZE_W) + 1;

    logic [EW-1:0] span_end;

    always_comb begin
        span_end = EW'(off) + EW'(size);
        ok = (off >= HEAD) &&
             (off[1:0] == 2'b00) &&
             (size >= SIZE_W'(8)) &&
             (span_end <= EW'(CFG_BYTES));
    end
endmodule

// File: rtl/xcap_step_limit.sv
module xcap_step_limit #(
    parameter int LIMIT = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/xcap_walker.sv
module xcap_walker
    import xcap_pkg::*;
#(
    parameter int               MAX_STEPS = 960,
    parameter int               REQ_ID_W  = 17,
    parameter int               SIZE_W    = 13,
    parameter logic [OFF_W-1:0] HEAD      = 12'h100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_append,
    input  logic [REQ_ID_W-1:0] cmd_id,
    input  logic [VER_W-1:0]    cmd_ver,
    input  logic [OFF_W-1:0]    cmd_off,
    input  logic [SIZE_W-1:0]   cmd_size,
    output logic                done,
    output logic                err,
    output logic [OFF_W-1:0]    res_off,
    output logic [OFF_W-1:0]    res_prev,
    output logic                ram_en,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [WORD_W-1:0]   ram_wdata,
    input  logic [WORD_W-1:0]   ram_rdata
);

    walk_st_e st_q, st_d;

    logic                app_q;
    logic [REQ_ID_W-1:0] id_q;
    logic [VER_W-1:0]    ver_q;
    logic [OFF_W-1:0]    aoff_q;
    logic [OFF_W-1:0]    cur_q;
    logic [OFF_W-1:0]    prev_q;
    logic [OFF_W-1:0]    res_off_q;
    logic [OFF_W-1:0]    res_prev_q;
    logic [VER_W+ID_W-1:0] tail_keep_q;

    cap_hdr_t hdr;
    logic     nxt_ok;
    logic     app_ok;
    logic     at_last;
    logic     is_empty;
    logic     is_hit;
    logic     is_end;
    logic     id_fits;

    xcap_hdr_unpack #(.HEAD(HEAD)) u_unpack (
        .word   (ram_rdata),
        .hdr    (hdr),
        .nxt_ok (nxt_ok)
    );

    xcap_append_check #(.HEAD(HEAD), .SIZE_W(SIZE_W)) u_acheck (
        .off  (cmd_off),
        .size (cmd_size),
        .ok   (app_ok)
    );

    xcap_step_limit #(.LIMIT(MAX_STEPS)) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_q == ST_IDLE),
        .inc   ((st_q == ST_EVAL) && (st_d == ST_READ)),
        .last  (at_last)
    );

    // Decisions taken while a header word is on ram_rdata
    always_comb begin
        id_fits  = ((id_q >> ID_W) == '0);
        is_empty = (cur_q == HEAD) && (ram_rdata == '0);
        is_hit   = !app_q && id_fits && (hdr.id == id_q[ID_W-1:0]);
        is_end   = (hdr.nxt == '0);
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (!cmd_append)          st_d = ST_READ;
                    else if (!app_ok)         st_d = ST_FAIL;
                    else if (cmd_off == HEAD) st_d = ST_WRITE;
                    else                      st_d = ST_READ;
                end
            end
            ST_READ:  st_d = ST_EVAL;
            ST_EVAL: begin
                if (is_empty)                st_d = app_q ? ST_FAIL : ST_DONE;
                else if (is_hit)             st_d = ST_DONE;
                else if (is_end)             st_d = app_q ? ST_PATCH : ST_DONE;
                else if (!nxt_ok || at_last) st_d = ST_FAIL;
                else                         st_d = ST_READ;
            end
            ST_PATCH: st_d = ST_WRITE;
            ST_WRITE: st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            ST_FAIL:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Walk pointers and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_q       <= 1'b0;
            id_q        <= '0;
            ver_q       <= '0;
            aoff_q      <= '0;
            cur_q       <= HEAD;
            prev_q      <= '0;
            res_off_q   <= '0;
            res_prev_q  <= '0;
            tail_keep_q <= '0;
        end else begin
            if (st_q == ST_IDLE && cmd_valid) begin
                app_q      <= cmd_append;
                id_q       <= cmd_id;
                ver_q      <= cmd_ver;
                aoff_q     <= cmd_off;
                cur_q      <= HEAD;
                prev_q     <= '0;
                res_off_q  <= cmd_append ? cmd_off : '0;
                res_prev_q <= '0;
            end
            if (st_q == ST_EVAL && !is_empty) begin
                if (st_d == ST_READ) begin
                    prev_q <= cur_q;
                    cur_q  <= hdr.nxt;
                end else if (is_hit) begin
                    res_off_q  <= cur_q;
                    res_prev_q <= prev_q;
                end else if (is_end) begin
                    res_prev_q  <= cur_q;
                    tail_keep_q <= {hdr.ver, hdr.id};
                end
            end
            if (st_d == ST_FAIL) begin
                res_off_q  <= '0;
                res_prev_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        done      = 1'b0;
        err       = 1'b0;
        unique case (st_q)
            ST_READ: begin
                ram_en   = 1'b1;
                ram_addr = cur_q[OFF_W-1:2];
            end
            ST_PATCH: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = cur_q[OFF_W-1:2];
                ram_wdata = {aoff_q, tail_keep_q};
            end
            ST_WRITE: begin
                ram_en    = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = aoff_q[OFF_W-1:2];
                ram_wdata = {{OFF_W{1'b0}}, ver_q, id_q[ID_W-1:0]};
            end
            ST_DONE: done = 1'b1;
            ST_FAIL: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: ;
        endcase
    end

    assign res_off  = res_off_q;
    assign res_prev = res_prev_q;

endmodule

// File: rtl/xcap_walker_chk.sv
module xcap_walker_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic err,
    input logic ram_en,
    input logic ram_we
);
    // R11: completion is a single-cycle pulse
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an error is only ever reported together with completion
    p_err_has_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R7: a write is always part of a RAM access
    p_write_has_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_en);

    // R11: every read is followed by an evaluate cycle without RAM access
    p_read_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we) |=> !ram_en);

    // R1: no RAM traffic in the completion cycle
    p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ram_en);
endmodule

bind xcap_walker xcap_walker_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .err    (err),
    .ram_en (ram_en),
    .ram_we (ram_we)
);

// File: tb/xcap_walker_tb_top.sv
module xcap_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXS       = 6;
    localparam int RIDW       = 17;
    localparam int SZW        = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_append = 1'b0;
    logic [RIDW-1:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_off = '0;
    logic [SZW-1:0] cmd_size = '0;
    logic done, err;
    logic [11:0] res_off, res_prev;
    logic ram_en, ram_we;
    logic [9:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata;

    logic [31:0] mem [0:1023];
    logic tb_we = 1'b0;
    logic [9:0] tb_addr = '0;
    logic [31:0] tb_data = '0;
    int wr_cnt = 0;
    int rd_cnt = 0;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcap_walker #(.MAX_STEPS(MAXS), .REQ_ID_W(RIDW), .SIZE_W(SZW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_append(cmd_append),
        .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
        .done(done), .err(err), .res_off(res_off), .res_prev(res_prev),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Behavioural RAM with one-cycle read latency, plus a bench poke port
    always @(posedge clk) begin
        if (tb_we) begin
            mem[tb_addr] <= tb_data;
        end else if (ram_en) begin
            if (ram_we) begin
                mem[ram_addr] <= ram_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
            ram_rdata <= mem[ram_addr];
        end
    end

    function automatic logic [31:0] hw(int nx, int ver, int id);
        return {nx[11:0], ver[3:0], id[15:0]};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic poke(int byte_off, logic [31:0] data);
        tb_addr = byte_off[11:2];
        tb_data = data;
        tb_we = 1'b1;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    // Reference walk over the bench RAM contents
    task automatic model_walk(bit app, int id, output int cyc, output bit e,
                              output int ro, output int rp);
        int cur = 256;
        int prv = 0;
        int n = 0;
        logic [31:0] w;
        int nx;
        if (mem[64] == 32'h0) begin
            e = app; cyc = 2; ro = 0; rp = 0;
            return;
        end
        forever begin
            n++;
            w = mem[cur/4];
            if (!app && id < 65536 && int'(w[15:0]) == id) begin
                e = 0; cyc = 2*n; ro = cur; rp = prv;
                return;
            end
            nx = int'(w[31:20]);
            if (nx == 0) begin
                e = 0; cyc = 2*n; ro = 0; rp = cur;
                return;
            end
            if ((nx % 4) != 0 || nx < 256 || nx > 4088 || n == MAXS) begin
                e = 1; cyc = 2*n; ro = 0; rp = 0;
                return;
            end
            prv = cur;
            cur = nx;
        end
    endtask

    // Issue one command; return completion cycle (edges after acceptance)
    task automatic issue(bit app, int id, int ver, int off, int size,
                         output int c, output bit e, output int ro, output int rp,
                         output bit pulse_ok);
        cmd_valid = 1'b1; cmd_append = app; cmd_id = id[RIDW-1:0];
        cmd_ver = ver[3:0]; cmd_off = off[11:0]; cmd_size = size[SZW-1:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        c = 0;
        while (!done && c < 5000) begin
            @(negedge clk);
            c++;
        end
        e = err; ro = res_off; rp = res_prev;
        @(negedge clk);
        pulse_ok = !done;
    endtask

    task automatic do_find(int id, string req);
        int ec, eo, ep, c, ro, rp, w0;
        bit ee, e, pk;
        model_walk(1'b0, id, ec, ee, eo, ep);
        w0 = wr_cnt;
        issue(1'b0, id, 0, 0, 0, c, e, ro, rp, pk);
        check(c == ec, "R11", {req, " lookup done cycle"}, c, ec);
        check(pk, "R11", {req, " done pulse width"}, int'(pk), 1);
        check(e == ee, req, "lookup err", int'(e), int'(ee));
        check(ro == eo, req, "lookup res_off", ro, eo);
        check(rp == ep, req, "lookup res_prev", rp, ep);
        check(wr_cnt == w0, "R3", "lookup RAM writes", wr_cnt - w0, 0);
    endtask

    task automatic do_append(int id, int ver, int off, int size, string req);
        int ec, eo, ep, c, ro, rp, w0, tail_prev;
        bit ee, e, pk, params_ok;
        logic [31:0] tail_word;
        params_ok = off >= 256 && (off % 4) == 0 && size >= 8 && off + size <= 4096;
        tail_prev = 0;
        tail_word = '0;
        if (!params_ok) begin
            ec = 0; ee = 1; eo = 0; ep = 0;
        end else if (off == 256) begin
            ec = 1; ee = 0; eo = 256; ep = 0;
        end else begin
            model_walk(1'b1, 0, ec, ee, eo, ep);
            if (!ee) begin
                ec = ec + 2; eo = off; tail_prev = ep;
                tail_word = {off[11:0], mem[ep/4][19:0]};
            end
        end
        w0 = wr_cnt;
        issue(1'b1, id, ver, off, size, c, e, ro, rp, pk);
        check(c == ec, "R11", {req, " insert done cycle"}, c, ec);
        check(pk, "R11", {req, " done pulse width"}, int'(pk), 1);
        check(e == ee, req, "insert err", int'(e), int'(ee));
        check(ro == eo, req, "insert res_off", ro, eo);
        check(rp == ep, req, "insert res_prev", rp, ep);
        if (ee) begin
            check(wr_cnt == w0, req, "RAM writes on error", wr_cnt - w0, 0);
        end else begin
            check(mem[off/4] == hw(0, ver, id), req, "new header word",
                  mem[off/4], hw(0, ver, id));
            if (off != 256)
                check(mem[tail_prev/4] == tail_word, "R7", "patched tail word",
                      mem[tail_prev/4], tail_word);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog expired actual=0x0 expected=0x1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int c, ro, rp;
        bit e, pk;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done && !err && !ram_en && !ram_we, "R1", "outputs in reset",
              {done, err, ram_en, ram_we}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 1024; i++) poke(i*4, 32'h0);
        @(negedge clk);
        check(!done && !err && !ram_en, "R1", "idle after reset",
              {done, err, ram_en}, 0);

        do_find(5, "R2");                       // empty chain
        do_append(12'h003, 1, 256, 16, "R6");   // insert at head
        do_append(12'h010, 2, 320, 8, "R7");    // 0x140, tail = head
        do_append(12'h00B, 1, 512, 32, "R7");   // 0x200, tail = 0x140
        check(mem[64] == hw(320, 1, 3), "R7", "head link field", mem[64], hw(320, 1, 3));
        do_find(16'h0010, "R3");
        do_find(16'h0003, "R3");
        do_find(16'h000B, "R3");
        do_find(16'h0099, "R4");
        do_find(17'h10010, "R5");

        // R8: rejected inserts
        do_append(7, 1, 252, 16, "R8");
        do_append(7, 1, 514, 16, "R8");
        do_append(7, 1, 1024, 4, "R8");
        do_append(7, 1, 4088, 16, "R8");

        // R9: corrupt links at the third header
        poke(512, hw(240, 1, 11));  do_find(16'h0099, "R9");
        poke(512, hw(518, 1, 11));  do_find(16'h0099, "R9");
        poke(512, hw(4092, 1, 11)); do_find(16'h0099, "R9");

        // R10: cycle 0x100 -> 0x140 -> 0x200 -> 0x100
        poke(512, hw(256, 1, 11));  do_find(16'h0099, "R10");

        // R10: chain of exactly MAX_STEPS headers completes
        for (int k = 0; k < MAXS; k++)
            poke(256 + 32*k, hw((k == MAXS-1) ? 0 : 256 + 32*(k+1), 1, 32 + k));
        do_find(16'h0099, "R10");
        do_append(12'h077, 3, 1024, 8, "R10");

        // R12: insert off-head into an empty chain
        poke(256, 32'h0);
        do_append(12'h021, 1, 384, 8, "R12");
        issue(1'b0, 5, 0, 0, 0, c, e, ro, rp, pk);
        check(ro == 0 && rp == 0 && !e, "R2", "chain still empty after R12 error",
              ro, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule